// File: doc/BRIEF.md
# Thirteen-Clock Framed Serial Byte Slave

This block is a serial slave that moves exactly one byte per framed transaction between an external master and two internal byte queues. The master supplies the serial clock (used directly as the block clock `clk`), an active-high select `cs`, and serial input `sdi`. The slave answers on `sdo`. Each frame opens with a start bit. Two setup bits then pick the operation, eight data bits follow with the most significant bit first, and the frame closes with a one-bit verdict that the slave returns. A frame runs 13 rising edges, numbered E0 to E12. The operations are: write a byte into the inbound queue, take a byte from the outbound queue, or fetch a flag byte that reports queue state.

Local logic fills the outbound queue through `tx_wr`/`tx_wr_data` and drains the inbound queue through `rx_rd`/`rx_rd_data`. Both queues read first-word-fall-through, and both run in the same clock domain as the frame engine. Two interrupt-enable bits from outside are reported in the flag byte and have no other effect here.

The frame engine is a state machine with these states:
- IDLE waits for a start.
- SETUP_DIR samples the direction bit.
- SETUP_TGT samples the target bit and latches the operation.
- SHIFT moves eight data bits.
- VERDICT presents the trailing bit, and commits at its closing edge.
- CLOSE is the last frame clock.
- HOLD waits for select to drop.

The transitions are:
- IDLE to SETUP_DIR on `cs`&`sdi` high.
- SETUP_DIR to SETUP_TGT.
- SETUP_TGT to SHIFT.
- SHIFT to VERDICT after the eighth data edge.
- VERDICT to CLOSE.
- CLOSE to IDLE after a flag-byte read, or CLOSE to HOLD after any other operation.
- HOLD to IDLE on `cs` low.
- Any of SETUP_DIR, SETUP_TGT, SHIFT or VERDICT returns to IDLE (abort) when `cs` is sampled low.

Top module: `spi13_slave`

## Requirements
- R1: A frame starts only at a rising edge (E0) where `cs` and `sdi` are both high. While `cs` is low, or while `sdi` is low, the engine stays idle and `sdo` is 0.
- R2: The setup bits are sampled at E1 (direction) and E2 (target). {1,0} takes a byte from the outbound queue, {1,1} reads the flag byte, and {0,0} writes to the inbound queue. {0,1} is unused: it changes no queue and returns verdict 1.
- R3: On a write, `sdi` is sampled MSB first at E3..E10. If the inbound queue is not full, the byte is appended at E11 and the verdict is 0.
- R4: A write to a full inbound queue returns verdict 1 and leaves the queue contents unchanged.
- R5: On a take from a non-empty outbound queue, `sdo` carries the head byte MSB first after E2..E9 (the master samples it at E3..E10). The verdict after E10 is 0, and the byte is removed at E11.
- R6: A take from an outbound queue that was empty at E2 returns verdict 1 and removes nothing.
- R7: The flag byte is sent like R5 with these bits: bit0 = inbound full, bit1 = outbound empty, bit4 = `rxf_ie`, bit5 = `txe_ie`, all other bits 0. Its verdict is 0.
- R8: If `cs` is sampled low at any edge E1..E11, the frame is abandoned and no queue is pushed or popped.
- R9: After a write, take or unused frame, no new start is accepted until `cs` has been sampled low. After a flag-byte read, a new start is accepted at E13 with `cs` still high.
- R10: After reset, `sdo` is 0, the inbound queue is empty and the outbound queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the master; all logic uses its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Active-high frame select |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data and verdict bit to the master |
| rxf_ie | input | 1 | Inbound-full interrupt enable, reported in the flag byte |
| txe_ie | input | 1 | Outbound-empty interrupt enable, reported in the flag byte |
| tx_wr | input | 1 | Append `tx_wr_data` to the outbound queue (ignored when full) |
| tx_wr_data | input | 8 | Byte for the outbound queue |
| tx_full | output | 1 | Outbound queue is full |
| rx_rd | input | 1 | Remove the head of the inbound queue (ignored when empty) |
| rx_rd_data | output | 8 | Head byte of the inbound queue |
| rx_empty | output | 1 | Inbound queue is empty |

## Verification
The bench targets the verdict bit at both queue extremes. A design that tests fullness at the wrong edge, or that samples emptiness after the pop, returns 0 on a full write or an empty take and corrupts the queues. It cuts frames short at many edges: an engine that commits before select is checked at E11 leaves a stray byte behind. It also holds select high across frames. A design that re-arms after a data frame accepts a phantom write, and one that blocks back-to-back flag reads loses the second flag byte. A shift register that runs one bit off shows up as rotated data under random bytes.

// File: rtl/spi13_pkg.sv
package spi13_pkg;

    localparam int BYTE_W = 8;

    // flag byte bit positions (decoded by the master)
    localparam int FB_RX_FULL  = 0;
    localparam int FB_TX_EMPTY = 1;
    localparam int FB_RX_IE    = 4;
    localparam int FB_TX_IE    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP_DIR,
        ST_SETUP_TGT,
        ST_SHIFT,
        ST_VERDICT,
        ST_CLOSE,
        ST_HOLD
    } frame_state_e;

    // {direction, target}
    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_UNUSED = 2'b01,
        OP_TAKE   = 2'b10,
        OP_FLAGS  = 2'b11
    } frame_op_e;

endpackage

// File: rtl/spi13_queue.sv
module spi13_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign pop_data = mem[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R4
    AST_QUEUE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R6

endmodule

// File: rtl/spi13_frame.sv
module spi13_frame
    import spi13_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sdi,
    output logic              sdo,
    input  logic              rxf_ie,
    input  logic              txe_ie,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_push_data,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_head,
    output logic              tx_pop
);
    localparam int CNT_W = $clog2(BYTE_W);

    frame_state_e       state_q, state_d;
    frame_op_e          op_q;
    logic               dir_q;
    logic [BYTE_W-1:0]  sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               take_ok_q;
    logic               verdict;
    logic [BYTE_W-1:0]  flag_byte;

    always_comb begin
        flag_byte = '0;
        flag_byte[FB_RX_FULL]  = rx_full;
        flag_byte[FB_TX_EMPTY] = tx_empty;
        flag_byte[FB_RX_IE]    = rxf_ie;
        flag_byte[FB_TX_IE]    = txe_ie;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cs && sdi) state_d = ST_SETUP_DIR;
            ST_SETUP_DIR: state_d = cs ? ST_SETUP_TGT : ST_IDLE;
            ST_SETUP_TGT: state_d = cs ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: begin
                if (!cs)                          state_d = ST_IDLE;
                else if (cnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_VERDICT;
            end
            ST_VERDICT:   state_d = cs ? ST_CLOSE : ST_IDLE;
            ST_CLOSE:     state_d = (op_q == OP_FLAGS) ? ST_IDLE : ST_HOLD;
            ST_HOLD:      if (!cs) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_UNUSED;
            dir_q     <= 1'b0;
            sh_q      <= '0;
            cnt_q     <= '0;
            take_ok_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SETUP_DIR: dir_q <= sdi;
                ST_SETUP_TGT: begin
                    op_q  <= frame_op_e'({dir_q, sdi});
                    cnt_q <= '0;
                    unique case (frame_op_e'({dir_q, sdi}))
                        OP_TAKE: begin
                            sh_q      <= tx_head;
                            take_ok_q <= !tx_empty;
                        end
                        OP_FLAGS: begin
                            sh_q      <= flag_byte;
                            take_ok_q <= 1'b0;
                        end
                        default: begin
                            sh_q      <= '0;
                            take_ok_q <= 1'b0;
                        end
                    endcase
                end
                ST_SHIFT: begin
                    sh_q  <= {sh_q[BYTE_W-2:0], (op_q == OP_WRITE) ? sdi : 1'b0};
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (op_q)
            OP_WRITE: verdict = rx_full;
            OP_TAKE:  verdict = !take_ok_q;
            OP_FLAGS: verdict = 1'b0;
            default:  verdict = 1'b1;
        endcase
        sdo          = 1'b0;
        rx_push      = 1'b0;
        tx_pop       = 1'b0;
        rx_push_data = sh_q;
        unique case (state_q)
            ST_SHIFT:   sdo = (op_q == OP_TAKE || op_q == OP_FLAGS) ? sh_q[BYTE_W-1] : 1'b0;
            ST_VERDICT: begin
                sdo     = verdict;
                rx_push = cs && (op_q == OP_WRITE) && !rx_full;
                tx_pop  = cs && (op_q == OP_TAKE) && take_ok_q;
            end
            default: ;
        endcase
    end

    AST_POP_HAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R6
    AST_COMMIT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || tx_pop) |-> ($past(state_q) == ST_SHIFT)); // R3
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (sdo == 1'b0)); // R8
    AST_HOLD_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (op_q != OP_FLAGS)); // R9
    AST_FLAGS_VERDICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERDICT && op_q == OP_FLAGS) |-> !sdo); // R7

endmodule

// File: rtl/spi13_slave.sv
module spi13_slave
    import spi13_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sdi,
    output logic              sdo,
    input  logic              rxf_ie,
    input  logic              txe_ie,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_rd_data,
    output logic              rx_empty
);
    logic              rx_full, rx_push;
    logic [BYTE_W-1:0] rx_push_data;
    logic              tx_empty, tx_pop;
    logic [BYTE_W-1:0] tx_head;

    spi13_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs           (cs),
        .sdi          (sdi),
        .sdo          (sdo),
        .rxf_ie       (rxf_ie),
        .txe_ie       (txe_ie),
        .rx_full      (rx_full),
        .rx_push      (rx_push),
        .rx_push_data (rx_push_data),
        .tx_empty     (tx_empty),
        .tx_head      (tx_head),
        .tx_pop       (tx_pop)
    );

    spi13_queue #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_rd),
        .pop_data  (rx_rd_data),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spi13_queue #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr),
        .push_data (tx_wr_data),
        .pop       (tx_pop),
        .pop_data  (tx_head),
        .full      (tx_full),
        .empty     (tx_empty)
    );

endmodule

// File: tb/spi13_slave_test.sv
module spi13_slave_test;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sdi = 1'b0, rxf_ie = 1'b0, txe_ie = 1'b0;
    logic tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic sdo, tx_full, rx_empty;
    logic [7:0] rx_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int q_rx[$];
    int q_tx[$];

    always #4 clk = ~clk;

    spi13_slave uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .sdo(sdo),
        .rxf_ie(rxf_ie), .txe_ie(txe_ie),
        .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int flags_exp(input bit rie, input bit tie);
        int v = 0;
        v[0] = (q_rx.size() == DEPTH);
        v[1] = (q_tx.size() == 0);
        v[4] = rie;
        v[5] = tie;
        return v;
    endfunction

    // one frame; inputs change at falling edges, sdo read at falling edges
    task automatic run_frame(input bit d, input bit a, input logic [7:0] wb,
                             input int abort_e, input bit rel,
                             output logic [7:0] rb, output logic st);
        rb = '0;
        st = 1'b0;
        for (int e = 0; e <= 12; e++) begin
            @(negedge clk);
            if (e >= 3 && e <= 10) rb[10-e] = sdo;
            if (e == 11) st = sdo;
            cs = (e < abort_e);
            if (e == 0)                sdi = 1'b1;
            else if (e == 1)           sdi = d;
            else if (e == 2)           sdi = a;
            else if (e >= 3 && e <= 10) sdi = wb[10-e];
            else                       sdi = 1'b0;
        end
        if (rel) begin
            @(negedge clk);
            cs = 1'b0;
            sdi = 1'b0;
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        check("R10 tx_full mirrors outbound count", int'(tx_full), int'(q_tx.size() == DEPTH));
        tx_wr = 1'b1;
        tx_wr_data = b;
        if (q_tx.size() < DEPTH) q_tx.push_back(int'(b));
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx(input string req);
        @(negedge clk);
        check({req, " rx_empty"}, int'(rx_empty), int'(q_rx.size() == 0));
        if (q_rx.size() > 0) begin
            check({req, " inbound byte"}, int'(rx_rd_data), q_rx[0]);
            void'(q_rx.pop_front());
        end
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] b);
        logic [7:0] rb;
        logic st;
        bit exp_st;
        exp_st = (q_rx.size() == DEPTH);
        run_frame(1'b0, 1'b0, b, 99, 1'b1, rb, st);
        check(exp_st ? "R4 full write verdict" : "R3 write verdict", int'(st), int'(exp_st));
        if (!exp_st) q_rx.push_back(int'(b));
    endtask

    task automatic do_take();
        logic [7:0] rb;
        logic st;
        run_frame(1'b1, 1'b0, 8'h00, 99, 1'b1, rb, st);
        if (q_tx.size() > 0) begin
            check("R5 take byte", int'(rb), q_tx[0]);
            check("R5 take verdict", int'(st), 0);
            void'(q_tx.pop_front());
        end else begin
            check("R6 empty take verdict", int'(st), 1);
        end
    endtask

    task automatic do_flags(input bit rel);
        logic [7:0] rb;
        logic st;
        int exp_b;
        exp_b = flags_exp(rxf_ie, txe_ie);
        run_frame(1'b1, 1'b1, 8'h00, 99, rel, rb, st);
        check("R7 flag byte", int'(rb), exp_b);
        check("R7 flag verdict", int'(st), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        logic st;
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 sdo after reset", int'(sdo), 0);
        check("R10 rx_empty after reset", int'(rx_empty), 1);
        check("R10 tx_full after reset", int'(tx_full), 0);
        do_flags(1'b1);

        // R1: sdi high with cs low, and cs high with sdi low: no frame
        sdi = 1'b1;
        cs = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R1 idle with cs low", int'(sdo), 0);
        end
        sdi = 1'b0;
        cs = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check("R1 idle with sdi low", int'(sdo), 0);
        end
        cs = 1'b0;
        do_write(8'hA5);
        pop_rx("R1 first frame after idle");

        // R2 unused setup code
        run_frame(1'b0, 1'b1, 8'h3C, 99, 1'b1, rb, st);
        check("R2 unused verdict", int'(st), 1);
        @(negedge clk);
        check("R2 unused leaves inbound empty", int'(rx_empty), 1);

        // R6 take from empty, R5 take with data
        do_take();
        push_tx(8'h81);
        push_tx(8'h7E);
        do_take();
        do_take();
        do_take();

        // R4 fill inbound queue then overflow write
        for (int i = 0; i < DEPTH + 2; i++) do_write(8'(8'h10 + i));
        rxf_ie = 1'b1;
        do_flags(1'b1);
        rxf_ie = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) pop_rx("R4 contents after overflow");

        // R8 aborted write and take
        for (int ab = 1; ab <= 11; ab++) begin
            run_frame(1'b0, 1'b0, 8'hEE, ab, 1'b1, rb, st);
            @(negedge clk);
            check("R8 aborted write leaves inbound empty", int'(rx_empty), 1);
        end
        push_tx(8'h5A);
        for (int ab = 1; ab <= 11; ab++) run_frame(1'b1, 1'b0, 8'h00, ab, 1'b1, rb, st);
        do_take();

        // R9 held select after a write blocks the next frame
        run_frame(1'b0, 1'b0, 8'hC3, 99, 1'b0, rb, st);
        check("R9 first held write verdict", int'(st), 0);
        q_rx.push_back(32'hC3);
        run_frame(1'b0, 1'b0, 8'h99, 99, 1'b1, rb, st);
        pop_rx("R9 only first write stored");
        @(negedge clk);
        check("R9 phantom write absent", int'(rx_empty), 1);

        // R9 back-to-back flag reads with select held
        txe_ie = 1'b1;
        push_tx(8'h01);
        do_flags(1'b0);
        do_flags(1'b0);
        do_flags(1'b1);
        txe_ie = 1'b0;
        do_take();

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(0, 4));
            rxf_ie = 1'($urandom_range(0, 1));
            txe_ie = 1'($urandom_range(0, 1));
            case (op)
                0: push_tx(8'($urandom_range(0, 255)));
                1: do_write(8'($urandom_range(0, 255)));
                2: do_take();
                3: do_flags(1'($urandom_range(0, 1)));
                default: pop_rx("R3 random inbound");
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule